// File: doc/BRIEF.md
# Multi-Limb Big-Integer Divider by Scalar

This block divides an unsigned big integer by one 64-bit scalar. The integer is stored outside the block as an array of 64-bit limbs, with index 0 the least significant. The block reaches the array through a limb port: one address, a combinational read-data input, and a write strobe with write data. A start pulse gives the index of the most significant limb, the divisor and a 64-bit carry-in. The block then walks the limbs from that index down to index 0.

At each limb the block builds a 128-bit dividend. The running carry forms the upper half and the limb forms the lower half. A restoring divider produces one quotient bit per clock. The quotient is written back over the limb, and the remainder becomes the carry for the next lower limb. When the walk ends, the final remainder is left on the remainder output and `done` pulses once. A single-limb mode performs only one step, on the addressed limb.

The block checks its inputs before it starts. If the divisor is zero, or the carry-in is not below the divisor, the quotient cannot fit in 64 bits. In that case the block raises an error flag, writes zero to the addressed limb, reports a zero remainder and stops.

Top module: `limbdiv_engine`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done`, `err` and `limb_we` are low and `rem_out` is zero.
- R2: Each step writes back to the same limb index the value floor(({carry, limb}) / divisor), where carry is bits 127:64 of the dividend and limb is bits 63:0. The remainder of that division becomes the carry for the next step.
- R3: In chained mode (`single_mode` = 0), the limbs are processed in the order `top_idx`, `top_idx`-1, ... 0, and each step uses the remainder of the step before it as its carry.
- R4: From the `done` cycle until the next accepted start, `rem_out` holds the final remainder and does not change.
- R5: In single-limb mode (`single_mode` = 1), only limb `top_idx` is divided and written, with `carry_in` as its upper half. No other limb is written.
- R6: If the divisor is zero, or `carry_in` >= divisor, `err` rises in the cycle after the start edge. In that same cycle limb `top_idx` is written with zero. `done` follows one cycle later with `rem_out` = 0, and no other limb is written.
- R7: Counting cycles from the clock edge that accepts start as cycle 0, the k-th limb write (k = 0 first) is presented in cycle 65+66k. `done` is high only in cycle 66N for N processed limbs, and for exactly one cycle.
- R8: A start pulse while `busy` is high is ignored. The operation in progress finishes with unchanged results and timing.
- R9: A later start with valid operands clears `err`, from the cycle after its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only while idle |
| single_mode | input | 1 | 1: process limb `top_idx` only |
| top_idx | input | IDX_W | Index of the most significant limb to process |
| divisor | input | LIMB_W | Scalar divisor, latched at start |
| carry_in | input | LIMB_W | Upper dividend half for the first step |
| busy | output | 1 | High from accepted start through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operand error flag of the latest operation |
| rem_out | output | LIMB_W | Final remainder |
| limb_addr | output | IDX_W | Limb index for read and write |
| limb_rdata | input | LIMB_W | Limb value at `limb_addr` (combinational) |
| limb_we | output | 1 | Limb write strobe |
| limb_wdata | output | LIMB_W | Quotient limb to write |

## Verification
The hardest case to reach from the ports is a step whose incoming carry is exactly one below the divisor. At that point every trial subtraction sits near the borrow boundary, and the 65-bit shifted partial remainder is at its largest. The bench reaches it by choosing the all-ones divisor with carry-in equal to divisor minus one, across eight limbs of mixed patterns. A reference model using 128-bit integer division predicts each quotient and the chained remainders. A second hard case is a start pulse that arrives in the middle of a run while the divisor and carry inputs change. The bench injects this during a chained run and compares every cycle of the write schedule with the undisturbed prediction.

// File: rtl/limbdiv_pkg.sv
package limbdiv_pkg;
   typedef enum logic [2:0] {
      LD_IDLE,
      LD_LOAD,
      LD_DIV,
      LD_WRITE,
      LD_ERRW,
      LD_FIN
   } ld_state_e;
endpackage

// File: rtl/limbdiv_step.sv
// One restoring-division iteration: shift the next dividend bit into the
// partial remainder, trial-subtract the divisor, keep or restore.
module limbdiv_step #(
   parameter int W        = 64,
   parameter int CMP_KIND = 0   // 0: borrow of one wide subtract, 1: separate compare
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dvs_i,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quo_o
);
   logic [W:0] shifted;
   logic       take;
   logic [W:0] reduced;

   assign shifted = {rem_i, quo_i[W-1]};

   generate
      if (CMP_KIND == 0) begin : g_borrow
         logic [W+1:0] diff;
         assign diff    = {1'b0, shifted} - {2'b00, dvs_i};
         assign take    = ~diff[W+1];
         assign reduced = diff[W:0];
      end else begin : g_compare
         assign take    = (shifted >= {1'b0, dvs_i});
         assign reduced = shifted - {1'b0, dvs_i};
      end
   endgenerate

   logic [W:0] chosen;
   logic       unused_msb;
   assign chosen     = take ? reduced : shifted;
   assign unused_msb = chosen[W];
   assign rem_o      = chosen[W-1:0];
   assign quo_o      = {quo_i[W-2:0], take};
endmodule

// File: rtl/limbdiv_seq.sv
// Control sequencer: walks limb indices downward, times the bit iterations.
module limbdiv_seq
   import limbdiv_pkg::*;
#(
   parameter int W     = 64,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             single_mode,
   input  logic [IDX_W-1:0] top_idx,
   input  logic             bad_ops,
   output ld_state_e        state,
   output logic [IDX_W-1:0] idx
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

   logic [CW-1:0] bit_cnt;
   logic          one_only;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= LD_IDLE;
         idx      <= '0;
         bit_cnt  <= '0;
         one_only <= 1'b0;
      end else begin
         unique case (state)
            LD_IDLE: begin
               if (start) begin
                  idx      <= top_idx;
                  one_only <= single_mode;
                  state    <= bad_ops ? LD_ERRW : LD_LOAD;
               end
            end
            LD_LOAD: begin
               bit_cnt <= '0;
               state   <= LD_DIV;
            end
            LD_DIV: begin
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_BIT) state <= LD_WRITE;
            end
            LD_WRITE: begin
               if (one_only || idx == '0) begin
                  state <= LD_FIN;
               end else begin
                  idx   <= idx - 1'b1;
                  state <= LD_LOAD;
               end
            end
            LD_ERRW: state <= LD_FIN;
            LD_FIN:  state <= LD_IDLE;
            default: state <= LD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/limbdiv_engine.sv
module limbdiv_engine
   import limbdiv_pkg::*;
#(
   parameter int  LIMB_W    = 64,
   parameter int  MAX_LIMBS = 8,
   parameter int  CMP_KIND  = 0,
   localparam int IDX_W     = (MAX_LIMBS > 1) ? $clog2(MAX_LIMBS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              single_mode,
   input  logic [IDX_W-1:0]  top_idx,
   input  logic [LIMB_W-1:0] divisor,
   input  logic [LIMB_W-1:0] carry_in,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [LIMB_W-1:0] rem_out,
   output logic [IDX_W-1:0]  limb_addr,
   input  logic [LIMB_W-1:0] limb_rdata,
   output logic              limb_we,
   output logic [LIMB_W-1:0] limb_wdata
);
   generate
      if (LIMB_W < 4) begin : g_bad_width
         $error("limbdiv_engine: LIMB_W must be at least 4");
      end
      if (MAX_LIMBS < 2 || (1 << IDX_W) != MAX_LIMBS) begin : g_bad_depth
         $error("limbdiv_engine: MAX_LIMBS must be a power of two >= 2");
      end
      if (CMP_KIND != 0 && CMP_KIND != 1) begin : g_bad_kind
         $error("limbdiv_engine: CMP_KIND must be 0 or 1");
      end
   endgenerate

   ld_state_e         state;
   logic [IDX_W-1:0]  idx;
   logic              bad_ops;
   logic [LIMB_W-1:0] rem_q, quo_q, dvs_q;
   logic [LIMB_W-1:0] rem_n, quo_n;
   logic              err_q;

   assign bad_ops = (divisor == '0) || (carry_in >= divisor);

   limbdiv_seq #(.W(LIMB_W), .IDX_W(IDX_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .single_mode (single_mode),
      .top_idx     (top_idx),
      .bad_ops     (bad_ops),
      .state       (state),
      .idx         (idx)
   );

   limbdiv_step #(.W(LIMB_W), .CMP_KIND(CMP_KIND)) u_step (
      .rem_i (rem_q),
      .quo_i (quo_q),
      .dvs_i (dvs_q),
      .rem_o (rem_n),
      .quo_o (quo_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         err_q <= 1'b0;
      end else begin
         unique case (state)
            LD_IDLE: begin
               if (start) begin
                  dvs_q <= divisor;
                  err_q <= bad_ops;
                  rem_q <= bad_ops ? '0 : carry_in;
               end
            end
            LD_LOAD: quo_q <= limb_rdata;
            LD_DIV: begin
               rem_q <= rem_n;
               quo_q <= quo_n;
            end
            default: ;
         endcase
      end
   end

   assign busy       = (state != LD_IDLE);
   assign done       = (state == LD_FIN);
   assign err        = err_q;
   assign rem_out    = rem_q;
   assign limb_addr  = idx;
   assign limb_we    = (state == LD_WRITE) || (state == LD_ERRW);
   assign limb_wdata = (state == LD_ERRW) ? '0 : quo_q;
endmodule

// File: rtl/limbdiv_chk.sv
module limbdiv_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         busy,
   input logic         done,
   input logic         err,
   input logic [W-1:0] rem_out,
   input logic         limb_we,
   input logic [W-1:0] limb_wdata,
   input logic [W-1:0] dvs_q
);
   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(limb_we));

   a_r6_err_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (err && limb_we) |-> (limb_wdata == '0));

   a_r6_err_rem_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rem_out == '0));

   a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (rem_out < dvs_q));

   a_r4_rem_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(rem_out));

   a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

bind limbdiv_engine limbdiv_chk #(.W(LIMB_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .rem_out    (rem_out),
   .limb_we    (limb_we),
   .limb_wdata (limb_wdata),
   .dvs_q      (dvs_q)
);

// File: tb/tb_limbdiv_engine.sv
`timescale 1ns/1ps
module tb_limbdiv_engine;
   localparam int W = 64;
   localparam int NL = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          single_mode = 1'b0;
   logic [IW-1:0] top_idx = '0;
   logic [W-1:0]  divisor = '0;
   logic [W-1:0]  carry_in = '0;
   logic          busy, done, err, limb_we;
   logic [W-1:0]  rem_out, limb_rdata, limb_wdata;
   logic [IW-1:0] limb_addr;

   logic [W-1:0]  mem [NL];
   logic [W-1:0]  exp_mem [NL];
   logic [W-1:0]  exp_q [NL];
   logic [W-1:0]  exp_rem;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   limbdiv_engine #(.LIMB_W(W), .MAX_LIMBS(NL)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .single_mode(single_mode),
      .top_idx(top_idx), .divisor(divisor), .carry_in(carry_in),
      .busy(busy), .done(done), .err(err), .rem_out(rem_out),
      .limb_addr(limb_addr), .limb_rdata(limb_rdata),
      .limb_we(limb_we), .limb_wdata(limb_wdata)
   );

   assign limb_rdata = mem[limb_addr];

   always @(posedge clk) begin
      if (limb_we) mem[limb_addr] <= limb_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   // Reference model: 128-bit integer division per limb, chained downward.
   task automatic run_op(input int top, input bit single, input logic [W-1:0] dv,
                         input logic [W-1:0] cin, input int inject_at);
      logic [2*W-1:0] dvd;
      logic [W-1:0]   c;
      bit             bad;
      int             n;
      int             tend;
      bad = (dv == '0) || (cin >= dv);
      n = single ? 1 : top + 1;
      for (int i = 0; i < NL; i++) exp_mem[i] = mem[i];
      if (bad) begin
         exp_mem[top] = '0;
         exp_rem = '0;
         tend = 1;
      end else begin
         c = cin;
         for (int k = 0; k < n; k++) begin
            dvd = {c, mem[top-k]};
            exp_q[k] = W'(dvd / {{W{1'b0}}, dv});
            c = W'(dvd % {{W{1'b0}}, dv});
            exp_mem[top-k] = exp_q[k];
         end
         exp_rem = c;
         tend = 66 * n;
      end
      start = 1'b1; single_mode = single; top_idx = IW'(top);
      divisor = dv; carry_in = cin;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t <= tend + 1; t++) begin
         bit ew, ed;
         int k;
         logic [IW-1:0] ea;
         logic [W-1:0]  edat;
         ew = 1'b0; ea = '0; edat = '0;
         if (bad) begin
            ew = (t == 0); ea = IW'(top); edat = '0;
            ed = (t == 1);
         end else begin
            ed = (t == tend);
            if (t >= 65 && ((t - 65) % 66) == 0) begin
               k = (t - 65) / 66;
               if (k < n) begin
                  ew = 1'b1; ea = IW'(top - k); edat = exp_q[k];
               end
            end
         end
         chk(limb_we == ew, "R7 write strobe timing", W'(limb_we), W'(ew));
         if (ew) begin
            chk(limb_addr == ea, "R3 limb write order", W'(limb_addr), W'(ea));
            chk(limb_wdata == edat, bad ? "R6 zero write on error" : "R2 quotient limb",
                limb_wdata, edat);
         end
         chk(done == ed, "R7 done pulse timing", W'(done), W'(ed));
         chk(busy == (t <= tend), "R8 busy span", W'(busy), W'(t <= tend));
         chk(err == bad, bad ? "R6 error flag" : "R9 error cleared", W'(err), W'(bad));
         if (ed) chk(rem_out == exp_rem, "R4 final remainder", rem_out, exp_rem);
         if (t == inject_at) begin
            start = 1'b1; divisor = '0; carry_in = '1; top_idx = '0; single_mode = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      for (int i = 0; i < NL; i++)
         chk(mem[i] == exp_mem[i], single ? "R5 other limbs untouched" : "R3 limb contents",
             mem[i], exp_mem[i]);
      repeat (3) @(negedge clk);
      chk(rem_out == exp_rem, "R4 remainder held", rem_out, exp_rem);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset values while held and after release
      chk(!busy && !done && !err && !limb_we, "R1 reset outputs",
          W'({busy, done, err, limb_we}), '0);
      chk(rem_out == '0, "R1 reset remainder", rem_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !limb_we && rem_out == '0, "R1 after release",
          W'({busy, done, err, limb_we}), '0);

      // R3 R2: three-limb chain with known answers
      mem[0] = 64'h1357_9BDF_9BDF_FEDC;
      mem[1] = 64'h9ABC_DEF0_DEF0_1357;
      mem[2] = 64'h1234_5678_5678_9ABC;
      run_op(2, 1'b0, 64'h1_0001, 64'h1234, -1);
      chk(mem[0] == 64'h1357_0000_9BDF_0000, "R2 known quotient 0", mem[0], 64'h1357_0000_9BDF_0000);
      chk(mem[1] == 64'h9ABC_0000_DEF0_0000, "R2 known quotient 1", mem[1], 64'h9ABC_0000_DEF0_0000);
      chk(mem[2] == 64'h1234_0000_5678_0000, "R2 known quotient 2", mem[2], 64'h1234_0000_5678_0000);
      chk(rem_out == 64'hFEDC, "R4 known remainder", rem_out, 64'hFEDC);

      // R5: single-limb step at index 0
      for (int i = 0; i < NL; i++) mem[i] = 64'hA5A5_0000_0000_0000 + 64'(i);
      mem[0] = 64'h0123_4567_89AB_CDEF;
      run_op(0, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0246_8ACE_1357_9BDF, -1);

      // R5: single-limb step in the middle of the array
      run_op(5, 1'b1, 64'h0000_0000_0000_0007, 64'h3, -1);

      // R2 R3: eight limbs, widest divisor, carry just below divisor
      for (int i = 0; i < NL; i++) mem[i] = {32'hFFFF_FFFF ^ 32'(i * 32'h1111_1111), 32'(i * 7 + 1)};
      mem[3] = '1; mem[6] = '0;
      run_op(7, 1'b0, '1, 64'hFFFF_FFFF_FFFF_FFFE, -1);

      // R2: divisor of one returns the limbs unchanged
      run_op(3, 1'b0, 64'h1, 64'h0, -1);

      // R6: zero divisor, then carry equal to divisor
      run_op(4, 1'b0, 64'h0, 64'h0, -1);
      run_op(2, 1'b0, 64'h55, 64'h55, -1);

      // R9: valid start after error clears err
      run_op(1, 1'b0, 64'hDEAD_BEEF, 64'h1234, -1);

      // R8: start pulse mid-run with different operands is ignored
      for (int i = 0; i < NL; i++) mem[i] = 64'h0F0F_F0F0_1234_5678 ^ {56'h0, 8'(i)};
      run_op(3, 1'b0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0000, 100);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule